// File: doc/BRIEF.md
# Cascadable Synchronous BCD Decade Counter Chain

The block is a chain of synchronous decimal counter cells. Each cell holds one BCD digit that runs 0 to 9 and then wraps to 0. All cells share one clock. A cell advances only when every lower digit is at 9 and the chain is being stepped, so with the default three cells the chain counts 000 to 999 and then wraps. Each cell builds its next state from per-bit toggle terms rather than from an adder, and the top-level carry output lets further chains be attached above it.

A synchronous load writes every digit at once and takes priority over counting. Stepping requires both the count enable and the carry input to be high, which lets the chain act as a higher section of a longer counter. A digit that has been loaded with one of the unused codes 10 to 15 falls back into the legal range within two steps.

Top module: `bcd_counter_chain`

## Requirements
- R1: While rst_n is low, every digit is 0 and carry_out is 0. The reset acts asynchronously.
- R2: A chain step occurs on a clock when cnt_en=1, carry_in=1 and load=0. On a step, digit 0 (digits[3:0]) goes from d to d+1 for d in 0..8, and from 9 to 0.
- R3: On a step, digit k (digits[4k+3:4k]) advances by the rule of R2 only if every lower digit is 9 before the edge. With three digits the chain goes from 999 to 000.
- R4: carry_out is combinational. It is 1 exactly when cnt_en=1, carry_in=1, load=0 and every digit equals 9.
- R5: When load=1, the next clock sets digit k to load_data[4k+3:4k], whatever cnt_en and carry_in are.
- R6: When load=0 and either cnt_en=0 or carry_in=0, every digit keeps its value.
- R7: A digit holding an unused code moves as follows when it is stepped: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2. It is therefore legal after at most two steps.
- R8: A digit holding a code other than 9, including the unused codes, never lets a step pass to the digit above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| carry_in | input | 1 | Cascade input from a lower section |
| load | input | 1 | Synchronous parallel load, with priority over counting |
| load_data | input | 4*DIGITS | Load values, 4 bits per digit, digit 0 in the low bits |
| digits | output | 4*DIGITS | BCD digits, digit 0 in the low bits |
| carry_out | output | 1 | Cascade output: stepping while all digits are 9 |

## Verification
A long uninterrupted count from 000 exercises every digit's wrap, and it shows whether each cascade boundary, up to the 999-to-000 rollover, passes a step only at 9. Interleaved hold phases with cnt_en low and with carry_in low show that each gate alone blocks counting and blocks carry_out. Loads issued while counting is enabled separate load priority from counting. Loads of each unused code, applied first to digit 0 and then to a higher digit with 9s below it, show the recovery path and show that an unused code stops the step from passing upward.

// File: rtl/bcd_chain_pkg.sv
package bcd_chain_pkg;
    localparam int unsigned BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    localparam bcd_t BCD_MAX = 4'd9;

    typedef struct packed {
        bcd_t digit;
    } cell_state_t;
endpackage

// File: rtl/bcd_decade_cell.sv
module bcd_decade_cell
    import bcd_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  bcd_t load_val,
    input  logic step_in,
    output bcd_t digit,
    output logic step_out
);
    cell_state_t state_d, state_q;
    bcd_t        tog;
    bcd_t        q;

    assign q = state_q.digit;

    // Per-bit toggle terms: bit0 always, bit1 = ~Q8&Q1, bit2 = Q2&Q1, bit3 = Q8&Q1 | Q4&Q2&Q1
    always_comb begin
        tog[0] = 1'b1;
        tog[1] = ~q[3] & q[0];
        tog[2] = q[1] & q[0];
        tog[3] = (q[3] & q[0]) | (q[2] & q[1] & q[0]);
    end

    always_comb begin
        state_d = state_q;
        if (load)
            state_d.digit = load_val;
        else if (step_in)
            state_d.digit = q ^ tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign digit    = q;
    assign step_out = step_in & (q == BCD_MAX);

    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && !load && q < BCD_MAX) |=> (q == $past(q) + 4'd1));
    p_wrap_nine_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && !load && q == BCD_MAX) |=> (q == 4'd0));
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val)));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_in) |=> $stable(q));
    p_illegal_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && !load && q > BCD_MAX && q[0]) |=> (q <= BCD_MAX));
    p_pass_only_nine_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |-> (q == BCD_MAX));
endmodule

// File: rtl/bcd_counter_chain.sv
module bcd_counter_chain
    import bcd_chain_pkg::*;
#(
    parameter int unsigned DIGITS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cnt_en,
    input  logic                      carry_in,
    input  logic                      load,
    input  logic [BCD_W*DIGITS-1:0]   load_data,
    output logic [BCD_W*DIGITS-1:0]   digits,
    output logic                      carry_out
);
    logic [DIGITS:0] step_chain;

    assign step_chain[0] = cnt_en & carry_in & ~load;

    for (genvar k = 0; k < DIGITS; k++) begin : g_cell
        bcd_decade_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (load_data[BCD_W*k +: BCD_W]),
            .step_in  (step_chain[k]),
            .digit    (digits[BCD_W*k +: BCD_W]),
            .step_out (step_chain[k+1])
        );
    end

    assign carry_out = step_chain[DIGITS];

    p_carry_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (cnt_en && carry_in && !load));
    p_top_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |=> (digits == '0));
endmodule

// File: tb/bcd_counter_chain_tb_top.sv
module bcd_counter_chain_tb_top;
    localparam int ND = 3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0, carry_in = 1'b0, load = 1'b0;
    logic [4*ND-1:0] load_data = '0;
    logic [4*ND-1:0] digits;
    logic carry_out;

    int n_checks = 0, n_fail = 0;
    int model [ND];

    bcd_counter_chain #(.DIGITS(ND)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .carry_in(carry_in),
        .load(load), .load_data(load_data), .digits(digits), .carry_out(carry_out)
    );

    always #10 clk = ~clk;

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    function automatic int next_code(int d);
        case (d)
            9: return 0;
            10: return 11;
            11: return 6;
            12: return 13;
            13: return 4;
            14: return 15;
            15: return 2;
            default: return d + 1;
        endcase
    endfunction

    function automatic int model_word();
        int w = 0;
        for (int k = ND - 1; k >= 0; k--) w = (w << 4) | model[k];
        return w;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // inputs are applied just after a falling edge; checks happen away from the rising edge
    task automatic cyc(string req, bit ld, int ldv, bit en, bit ci);
        bit all9, pass;
        load = ld; load_data = ldv[4*ND-1:0]; cnt_en = en; carry_in = ci;
        #1;
        all9 = 1'b1;
        for (int k = 0; k < ND; k++) if (model[k] != 9) all9 = 1'b0;
        check("R4", int'(carry_out), int'(en && ci && !ld && all9));
        @(posedge clk);
        if (ld) begin
            for (int k = 0; k < ND; k++) model[k] = (ldv >> (4*k)) & 15;
        end else if (en && ci) begin
            pass = 1'b1;
            for (int k = 0; k < ND; k++) begin
                if (pass) begin
                    int old = model[k];
                    model[k] = next_code(old);
                    pass = (old == 9);
                end
            end
        end
        @(negedge clk);
        check(req, int'(digits), model_word());
    endtask

    initial begin
        for (int k = 0; k < ND; k++) model[k] = 0;
        #5;
        check("R1", int'(digits), 0);
        check("R1", int'(carry_out), 0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(digits), 0);

        // R2 and R3: long count through the 999 rollover
        for (int i = 0; i < 1010; i++) cyc("R3", 0, 0, 1, 1);
        // R6: each gate alone holds
        for (int i = 0; i < 4; i++) cyc("R6", 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) cyc("R6", 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc("R2", 0, 0, 1, 1);
        // R5: load wins over counting
        cyc("R5", 1, 'h998, 1, 1);
        cyc("R5", 1, 'h123, 0, 0);
        cyc("R5", 1, 'h998, 1, 1);
        for (int i = 0; i < 3; i++) cyc("R3", 0, 0, 1, 1);
        // R7: unused codes in digit 0
        for (int c = 10; c < 16; c++) begin
            cyc("R5", 1, 'h090 | c, 0, 0);
            cyc("R7", 0, 0, 1, 1);
            cyc("R7", 0, 0, 1, 1);
            cyc("R7", 0, 0, 1, 1);
        end
        // R8: unused code in digit 1 with 9 below; step must stop at digit 1
        for (int c = 10; c < 16; c++) begin
            cyc("R5", 1, 'h509 | (c << 4), 0, 0);
            cyc("R8", 0, 0, 1, 1);
            cyc("R8", 0, 0, 1, 1);
        end
        cyc("R5", 1, 'h999, 0, 0);
        cyc("R4", 0, 0, 1, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule